// File: doc/BRIEF.md
# Temperature-Indexed Supply Voltage Selector

This controller chooses a supply-voltage level code from a stream of die-temperature samples while the clock frequency stays fixed. The circuits it serves get faster as they heat up. Above a level's threshold temperature, a lower supply still meets timing. The controller therefore lowers the supply as the die warms and raises it again as the die cools. It never raises the supply because of heat.

A table is loaded once. It holds one threshold temperature per lower level, one equilibrium temperature per level, a valid bit per lower level, a warm-up length and a temperature limit. At load time the controller chooses one of three policies:

- **Plain region following.** Used when some level's equilibrium temperature falls inside that level's own region.
- **Stationary cycling.** Used when some level's equilibrium temperature lies below its own threshold. The smallest such level becomes the target, and the controller holds the die close to that level's threshold.
- **Region following with an over-limit alarm.** Used when neither of the above applies.

The controller has three states. FOLLOW applies the region level. WARM holds the level just below the target for at least the warm-up interval. HOLD applies the target level. It has three transitions:

- enter-warm: FOLLOW→WARM, or HOLD→WARM as the raise.
- drop: WARM→HOLD, or FOLLOW→HOLD.
- fall-back: WARM→FOLLOW.

A table load forces FOLLOW.

Top module: `thermal_vsel`

## Requirements
- R1: After reset the level is 1, the change strobe is 0, the mode indicator is 0 and the over-limit flag is 0.
- R2: Level code k means base supply minus 0.05 V times (k−1), and the level is always in 1..N. Table packing:
  - The threshold for level k (k≥2) is at `tth_i[(k-2)*8 +: 8]`.
  - The equilibrium temperature for level k (k≥1) is at `teq_i[(k-1)*8 +: 8]`.
  - The valid bit for level k is `lvl_en_i[k-2]`.
  - All temperatures are signed 8-bit °C.
- R3: Each accepted sample sets the level, one edge later, to the highest candidate level whose threshold is ≤ the sample, or to 1 if there is none. This applies in FOLLOW state and assumes candidate thresholds ascend.
- R4: A level is a candidate only if it is valid and its threshold is below the loaded limit. A level that is not a candidate is never output.
- R5: `chg_o` is high for exactly one cycle after each edge at which the level changes. The level changes only at edges where `temp_vld_i` is high and no load is taken. Without valid, the temperature input has no effect.
- R6: The policy is recomputed only at an edge with `tbl_load_i` high. A load wins over a sample taken in the same cycle, and that sample is ignored. When some level k has an equilibrium temperature inside [Tth_k, next candidate threshold or limit), the controller only follows regions and `stat_mode_o` is 0. Level 1's region has no lower bound.
- R7: Otherwise, if some candidate k≥2 has an equilibrium temperature below Tth_k, `stat_mode_o` is 1 from the edge after the load. The target S is the smallest such k, and P is the next lower candidate.
- R8: In stationary mode, FOLLOW applies the region level while it is below P. A sample whose region level is P enters WARM at level P. A sample whose region level is S or above goes to HOLD at level S.
- R9: In WARM, a sample at the (W+1)-th edge or later after the entering edge drops the level to S, provided the sample is ≥ Tth_S. A sample below Tth_P returns to FOLLOW at its region level.
- R10: In HOLD the level stays at S while samples are ≥ Tth_S. A sample below Tth_S raises the level to P and restarts WARM.
- R11: `over_lim_o` can be set only under the third policy, where it equals (last accepted sample ≥ limit). A load clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_i | input | TW | Signed die-temperature sample, °C |
| temp_vld_i | input | 1 | Sample valid strobe |
| tbl_load_i | input | 1 | Load table and recompute policy |
| tth_i | input | (N-1)*TW | Thresholds, levels 2..N |
| teq_i | input | N*TW | Equilibrium temperatures, levels 1..N |
| lvl_en_i | input | N-1 | Valid bits, levels 2..N |
| warm_cyc_i | input | CW | Warm-up length W in cycles |
| tlim_i | input | TW | Die temperature limit |
| lvl_o | output | LW | Selected level code, 1 = base supply |
| chg_o | output | 1 | One-cycle level-change strobe |
| stat_mode_o | output | 1 | Stationary policy selected |
| over_lim_o | output | 1 | Temperature at or above limit |

## Verification
Level, change strobe and over-limit flag are all due one edge after the sample that causes them. The mode indicator is due one edge after the load. The bench drives every input at a falling edge and reads the outputs at the next falling edge, half a period after the edge that updates them. The warm-up boundary is counted in edges from the one that entered WARM. The bench places samples at the W-th and (W+1)-th edge to see the drop refused and then accepted.

// File: rtl/thermal_vsel_pkg.sv
package thermal_vsel_pkg;

    typedef enum logic [1:0] {
        POL_EQ   = 2'd0,
        POL_STAT = 2'd1,
        POL_NONE = 2'd2
    } policy_e;

    typedef enum logic [1:0] {
        ST_FOLLOW = 2'd0,
        ST_WARM   = 2'd1,
        ST_HOLD   = 2'd2
    } state_e;

endpackage

// File: rtl/tvs_region_lookup.sv
module tvs_region_lookup #(
    parameter int N  = 8,
    parameter int TW = 8,
    parameter int LW = 4
) (
    input  logic [TW-1:0]     temp,
    input  logic [(N-1)*TW-1:0] tth_hi,
    input  logic [N-2:0]      cand_hi,
    output logic [LW-1:0]     lvl
);

    // highest candidate whose threshold the temperature has reached
    always_comb begin
        lvl = LW'(1);
        for (int k = 1; k < N; k++) begin
            if (cand_hi[k-1] && ($signed(temp) >= $signed(tth_hi[(k-1)*TW +: TW])))
                lvl = LW'(k + 1);
        end
    end

endmodule

// File: rtl/tvs_policy.sv
module tvs_policy
    import thermal_vsel_pkg::*;
#(
    parameter int N  = 8,
    parameter int TW = 8,
    parameter int LW = 4
) (
    input  logic [(N-1)*TW-1:0] tth_hi,
    input  logic [N*TW-1:0]     teq,
    input  logic [N-2:0]        cand_hi,
    input  logic [TW-1:0]       tlim,
    output policy_e             pol,
    output logic [LW-1:0]       tgt,
    output logic [LW-1:0]       prv
);

    logic signed [TW-1:0] upper;
    logic                 in_any;
    logic                 found;
    logic [LW-1:0]        last;

    always_comb begin
        // pass 1: does any level settle inside its own region
        upper  = $signed(tlim);
        in_any = 1'b0;
        for (int k = N - 1; k >= 1; k--) begin
            if (cand_hi[k-1]) begin
                if (($signed(teq[k*TW +: TW]) >= $signed(tth_hi[(k-1)*TW +: TW])) &&
                    ($signed(teq[k*TW +: TW]) < upper))
                    in_any = 1'b1;
                upper = $signed(tth_hi[(k-1)*TW +: TW]);
            end
        end
        if ($signed(teq[TW-1:0]) < upper)
            in_any = 1'b1;

        // pass 2: smallest level that cools below its own threshold
        found = 1'b0;
        tgt   = LW'(1);
        prv   = LW'(1);
        last  = LW'(1);
        for (int k = 1; k < N; k++) begin
            if (cand_hi[k-1]) begin
                if (!found && ($signed(teq[k*TW +: TW]) < $signed(tth_hi[(k-1)*TW +: TW]))) begin
                    found = 1'b1;
                    tgt   = LW'(k + 1);
                    prv   = last;
                end
                last = LW'(k + 1);
            end
        end

        if (in_any)
            pol = POL_EQ;
        else if (found)
            pol = POL_STAT;
        else
            pol = POL_NONE;
    end

endmodule

// File: rtl/tvs_warm_timer.sv
module tvs_warm_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [CW-1:0] limit,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    assign done = (cnt_q >= limit);

    // saturates at the limit, so it can never wrap
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (!done)
            cnt_q <= cnt_q + CW'(1);
    end

endmodule

// File: rtl/thermal_vsel.sv
module thermal_vsel
    import thermal_vsel_pkg::*;
#(
    parameter int N         = 8,
    parameter int TW        = 8,
    parameter int CW        = 16,
    parameter int DEF_LIMIT = 90
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TW-1:0]        temp_i,
    input  logic                 temp_vld_i,
    input  logic                 tbl_load_i,
    input  logic [(N-1)*TW-1:0]  tth_i,
    input  logic [N*TW-1:0]      teq_i,
    input  logic [N-2:0]         lvl_en_i,
    input  logic [CW-1:0]        warm_cyc_i,
    input  logic [TW-1:0]        tlim_i,
    output logic [$clog2(N+1)-1:0] lvl_o,
    output logic                 chg_o,
    output logic                 stat_mode_o,
    output logic                 over_lim_o
);

    localparam int LW = $clog2(N + 1);

    // candidate screening of incoming table
    logic [N-2:0] cand_in;

    generate
        for (genvar g = 0; g < N - 1; g++) begin : g_cand
            assign cand_in[g] = lvl_en_i[g] &&
                                ($signed(tth_i[g*TW +: TW]) < $signed(tlim_i));
        end
    endgenerate

    policy_e       pol_in;
    logic [LW-1:0] tgt_in;
    logic [LW-1:0] prv_in;

    tvs_policy #(.N(N), .TW(TW), .LW(LW)) u_policy (
        .tth_hi  (tth_i),
        .teq     (teq_i),
        .cand_hi (cand_in),
        .tlim    (tlim_i),
        .pol     (pol_in),
        .tgt     (tgt_in),
        .prv     (prv_in)
    );

    // loaded configuration
    logic [(N-1)*TW-1:0] tth_q;
    logic [N-2:0]        cand_q;
    logic [TW-1:0]       tlim_q;
    logic [CW-1:0]       warm_q;
    policy_e             pol_q;
    logic [LW-1:0]       tgt_q;
    logic [LW-1:0]       prv_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tth_q  <= '0;
            cand_q <= '0;
            tlim_q <= TW'(DEF_LIMIT);
            warm_q <= '0;
            pol_q  <= POL_EQ;
            tgt_q  <= LW'(1);
            prv_q  <= LW'(1);
        end else if (tbl_load_i) begin
            tth_q  <= tth_i;
            cand_q <= cand_in;
            tlim_q <= tlim_i;
            warm_q <= warm_cyc_i;
            pol_q  <= pol_in;
            tgt_q  <= tgt_in;
            prv_q  <= prv_in;
        end
    end

    // region level of the live sample
    logic [LW-1:0] reg_lvl;

    tvs_region_lookup #(.N(N), .TW(TW), .LW(LW)) u_region (
        .temp    (temp_i),
        .tth_hi  (tth_q),
        .cand_hi (cand_q),
        .lvl     (reg_lvl)
    );

    // thresholds of target and the level below it
    int                   tgt_idx;
    int                   prv_idx;
    logic signed [TW-1:0] tth_tgt;
    logic signed [TW-1:0] tth_prv;
    logic                 below_tgt;
    logic                 below_prv;

    always_comb begin
        tgt_idx   = (tgt_q >= LW'(2)) ? int'(tgt_q) - 2 : 0;
        prv_idx   = (prv_q >= LW'(2)) ? int'(prv_q) - 2 : 0;
        tth_tgt   = $signed(tth_q[tgt_idx*TW +: TW]);
        tth_prv   = $signed(tth_q[prv_idx*TW +: TW]);
        below_tgt = ($signed(temp_i) < tth_tgt);
        below_prv = (prv_q >= LW'(2)) && ($signed(temp_i) < tth_prv);
    end

    // state machine
    state_e        state_q;
    state_e        state_d;
    logic [LW-1:0] lvl_q;
    logic [LW-1:0] lvl_d;
    logic          over_q;
    logic          over_d;
    logic          chg_q;
    logic          warm_done;
    logic          stat_pol;

    assign stat_pol = (pol_q == POL_STAT);

    tvs_warm_timer #(.CW(CW)) u_warm (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q != ST_WARM),
        .limit (warm_q),
        .done  (warm_done)
    );

    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        over_d  = over_q;
        if (tbl_load_i) begin
            state_d = ST_FOLLOW;
            over_d  = 1'b0;
        end else if (temp_vld_i) begin
            over_d = (pol_q == POL_NONE) && ($signed(temp_i) >= $signed(tlim_q));
            unique case (state_q)
                ST_FOLLOW: begin
                    if (stat_pol && (reg_lvl >= tgt_q)) begin
                        state_d = ST_HOLD;          // drop
                        lvl_d   = tgt_q;
                    end else if (stat_pol && (reg_lvl >= prv_q)) begin
                        state_d = ST_WARM;          // enter-warm
                        lvl_d   = prv_q;
                    end else begin
                        lvl_d   = reg_lvl;
                    end
                end
                ST_WARM: begin
                    if (below_prv) begin
                        state_d = ST_FOLLOW;        // fall-back
                        lvl_d   = reg_lvl;
                    end else if (warm_done && !below_tgt) begin
                        state_d = ST_HOLD;          // drop
                        lvl_d   = tgt_q;
                    end
                end
                ST_HOLD: begin
                    if (below_tgt) begin
                        state_d = ST_WARM;          // raise
                        lvl_d   = prv_q;
                    end
                end
                default: begin
                    state_d = ST_FOLLOW;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_FOLLOW;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= LW'(1);
            chg_q  <= 1'b0;
            over_q <= 1'b0;
        end else begin
            lvl_q  <= lvl_d;
            chg_q  <= (lvl_d != lvl_q);
            over_q <= over_d;
        end
    end

    assign lvl_o       = lvl_q;
    assign chg_o       = chg_q;
    assign stat_mode_o = stat_pol;
    assign over_lim_o  = over_q;

endmodule

// File: rtl/thermal_vsel_chk.sv
module tvs_sel_chk #(
    parameter int N = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   temp_vld_i,
    input logic                   tbl_load_i,
    input logic [$clog2(N+1)-1:0] lvl_o,
    input logic                   chg_o,
    input logic                   stat_mode_o,
    input logic                   over_lim_o
);

    // R5
    chg_on_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_o != $past(lvl_o)) |-> chg_o);

    // R5
    chg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o |-> (lvl_o != $past(lvl_o)));

    // R5
    move_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_o != $past(lvl_o)) |-> ($past(temp_vld_i) && !$past(tbl_load_i)));

    // R2
    lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_o >= 1) && (lvl_o <= N));

    // R6
    mode_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_mode_o != $past(stat_mode_o)) |-> $past(tbl_load_i));

    // R11
    over_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        over_lim_o |-> !stat_mode_o);

endmodule

bind thermal_vsel tvs_sel_chk #(.N(N)) u_tvs_sel_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .temp_vld_i  (temp_vld_i),
    .tbl_load_i  (tbl_load_i),
    .lvl_o       (lvl_o),
    .chg_o       (chg_o),
    .stat_mode_o (stat_mode_o),
    .over_lim_o  (over_lim_o)
);

// File: tb/test_thermal_vsel.sv
`timescale 1ns/1ps
module test_thermal_vsel;

    localparam int N  = 8;
    localparam int TW = 8;
    localparam int CW = 16;
    localparam int LW = $clog2(N + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [TW-1:0]        temp_i = '0;
    logic                 temp_vld_i = 1'b0;
    logic                 tbl_load_i = 1'b0;
    logic [(N-1)*TW-1:0]  tth_i = '0;
    logic [N*TW-1:0]      teq_i = '0;
    logic [N-2:0]         lvl_en_i = '0;
    logic [CW-1:0]        warm_cyc_i = '0;
    logic [TW-1:0]        tlim_i = '0;
    logic [LW-1:0]        lvl_o;
    logic                 chg_o;
    logic                 stat_mode_o;
    logic                 over_lim_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    thermal_vsel #(.N(N), .TW(TW), .CW(CW)) i_thermal_vsel (
        .clk, .rst_n, .temp_i, .temp_vld_i, .tbl_load_i, .tth_i, .teq_i,
        .lvl_en_i, .warm_cyc_i, .tlim_i, .lvl_o, .chg_o, .stat_mode_o, .over_lim_o
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // thresholds: L2=18, L3=61, L4=95 (over limit), L5=70 (invalid); limit 90
    task automatic set_cfg(input int e1, input int e2, input int e3, input int w);
        tth_i = '0;
        teq_i = '0;
        tth_i[0*TW +: TW] = 8'(18);
        tth_i[1*TW +: TW] = 8'(61);
        tth_i[2*TW +: TW] = 8'(95);
        tth_i[3*TW +: TW] = 8'(70);
        lvl_en_i   = 7'b0000111;
        teq_i[0*TW +: TW] = 8'(e1);
        teq_i[1*TW +: TW] = 8'(e2);
        teq_i[2*TW +: TW] = 8'(e3);
        warm_cyc_i = CW'(w);
        tlim_i     = 8'(90);
    endtask

    task automatic do_load();
        tbl_load_i = 1'b1;
        @(negedge clk);
        tbl_load_i = 1'b0;
    endtask

    task automatic sample(input int t);
        temp_i     = 8'(t);
        temp_vld_i = 1'b1;
        @(negedge clk);
        temp_vld_i = 1'b0;
    endtask

    function automatic int exp_region(input int t);
        if (t >= 61) return 3;
        if (t >= 18) return 2;
        return 1;
    endfunction

    // R3 R4 R5 R11: sweep up then down, single-step samples
    task automatic sweep(input bit none_mode);
        int prev_l;
        prev_l = lvl_o;
        for (int t = -25; t <= 100; t++) begin
            sample(t);
            chk("R3 sweep up level", lvl_o, exp_region(t));
            chk("R5 sweep up strobe", chg_o, (exp_region(t) != prev_l) ? 1 : 0);
            chk("R11 sweep up over", over_lim_o, (none_mode && t >= 90) ? 1 : 0);
            prev_l = exp_region(t);
        end
        for (int t = 100; t >= -25; t--) begin
            sample(t);
            chk("R3 sweep down level", lvl_o, exp_region(t));
            chk("R5 sweep down strobe", chg_o, (exp_region(t) != prev_l) ? 1 : 0);
            prev_l = exp_region(t);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 reset level", lvl_o, 1);
        chk("R1 reset strobe", chg_o, 0);
        chk("R1 reset mode", stat_mode_o, 0);
        chk("R1 reset over", over_lim_o, 0);

        // R6: load with simultaneous sample; sample ignored, policy I
        set_cfg(50, 40, 99, 5);
        temp_i = 8'(70);
        temp_vld_i = 1'b1;
        do_load();
        temp_vld_i = 1'b0;
        chk("R6 load beats sample level", lvl_o, 1);
        chk("R6 load beats sample strobe", chg_o, 0);
        chk("R6 equilibrium in region mode", stat_mode_o, 0);

        // R5: no valid, no effect
        temp_i = 8'(70);
        repeat (3) @(negedge clk);
        chk("R5 no valid level", lvl_o, 1);
        chk("R5 no valid strobe", chg_o, 0);

        // R3 R4 sweep in policy-I mode; R11 over never set
        sweep(1'b0);
        sample(95);
        chk("R11 over only in none mode", over_lim_o, 0);
        sample(-25);

        // R6: new table without load has no effect
        set_cfg(50, 70, 44, 5);
        repeat (2) @(negedge clk);
        chk("R6 no load no mode", stat_mode_o, 0);
        sample(20);
        chk("R6 old table follow", lvl_o, 2);
        sample(0);
        chk("R3 back to base", lvl_o, 1);

        // R7: stationary, S=3, P=2, W=5
        do_load();
        chk("R7 stationary mode", stat_mode_o, 1);
        sample(0);
        chk("R8 follow below P", lvl_o, 1);
        sample(20);
        chk("R8 enter warm at P", lvl_o, 2);
        repeat (4) @(negedge clk);
        sample(62);
        chk("R9 drop refused at edge W", lvl_o, 2);
        chk("R9 no strobe at edge W", chg_o, 0);
        sample(62);
        chk("R9 drop at edge W+1", lvl_o, 3);
        chk("R9 drop strobe", chg_o, 1);
        sample(61);
        chk("R10 hold at threshold", lvl_o, 3);
        sample(60);
        chk("R10 raise below threshold", lvl_o, 2);
        chk("R10 raise strobe", chg_o, 1);
        sample(65);
        chk("R10 warm restarted", lvl_o, 2);
        repeat (3) @(negedge clk);
        sample(65);
        chk("R9 restarted warm edge W", lvl_o, 2);
        sample(65);
        chk("R9 restarted warm edge W+1", lvl_o, 3);
        sample(60);
        chk("R10 second raise", lvl_o, 2);
        sample(17);
        chk("R9 fall back below P", lvl_o, 1);
        sample(70);
        chk("R8 follow straight to S", lvl_o, 3);
        sample(100);
        chk("R4 excluded level never used", lvl_o, 3);
        chk("R11 no over in stationary", over_lim_o, 0);

        // R11: no qualifying level
        set_cfg(50, 70, 99, 5);
        do_load();
        chk("R11 none mode indicator", stat_mode_o, 0);
        sweep(1'b1);
        sample(120);
        chk("R4 top excluded level", lvl_o, 3);
        chk("R11 over at 120", over_lim_o, 1);
        do_load();
        chk("R11 load clears over", over_lim_o, 0);
        sample(89);
        chk("R11 just below limit", over_lim_o, 0);
        sample(90);
        chk("R11 at limit", over_lim_o, 1);
        sample(30);
        chk("R11 cooled", over_lim_o, 0);
        chk("R3 cooled level", lvl_o, 2);

        summary();
        $finish;
    end

endmodule